// File: doc/BRIEF.md
# Pointer-Driven Configuration Sequencer

This block steps a downstream circuit through a programmed series of configurations without a register write for each step. A table of configuration words (modes) is loaded through a synchronous write port. A second table gives, for each numbered state, the mode that the state selects. A pointer moves through the states. Pulses on an advance pin move it forward, and pulses on a reset pin return it to the start. Software can raise the same two events by setting bits in the control register.

The start position is a fixed home state. It always selects mode 0 and cannot be remapped. The programmed depth n counts only the states after home, so states 1 to n are visited in turn, and one more advance goes back to home. When an advance or reset event rises, the selected mode word is loaded into a holding register.

A commit stage sits last, just before the outputs. It passes the holding register through at once, or, when latching is selected, only when the pulse falls, so all output bits switch together. While the sequencer is disabled, the pointer is held at home and the manual configuration register is the source. The commit stage still applies, so with latching on a manual value waits for a pin pulse.

The commit stage has three named states:
- `CM_PASS` (latching off): the output follows the source on every cycle.
- `CM_HOLD` (latching on, idle): the output is frozen.
- `CM_ARMED` (latching on, after a rising event): the output waits for the falling event.

Its transitions are:
- PASS to HOLD when latching is turned on.
- HOLD to ARMED on a rising event.
- ARMED to HOLD on a falling event, which commits the source to the output.
- HOLD or ARMED to PASS when latching is turned off.

Top module: `mode_sequencer`

## Requirements
- R1: After reset, `cfg_out`, `cur_state` and `cur_mode` are all zero, the sequencer is disabled and latching is off.
- R2: While disabled (control bit 0 = 0) with latching off, `cfg_out` follows the manual register (address 0x02), and advance pulses leave `cur_state` at 0.
- R3: When enabled, each advance (pin rising edge) moves `cur_state` from s to s+1 for s < n. `cur_mode` becomes the mode index held for the new state (address 0x20+s), and `cfg_out` becomes that mode's word (address 0x10+m). A mode may be used by several states, in any order.
- R4: An advance from state n, where n is the depth at address 0x01, returns to state 0. With n = 0 the pointer stays at 0.
- R5: State 0 always selects mode 0. A write to address 0x20 has no effect.
- R6: A reset event (pin rising edge, or control bit 3) returns the pointer to state 0 with mode 0 from any state.
- R7: Writing control bit 2 acts as one advance pulse.
- R8: When reset and advance events occur in the same cycle, reset wins and the pointer goes to state 0.
- R9: With latching on (control bit 1 = 1), `cur_state` and `cur_mode` update on the rising edge of the pulse, but `cfg_out` keeps its old value until the pulse falls and then takes the new word.
- R10: With latching on and the sequencer disabled, a new manual value does not reach `cfg_out` until a pin pulse falls.
- R11: A depth write larger than MAX_STATES is stored as MAX_STATES, so with the defaults the eighth advance from home wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_pin | input | 1 | Asynchronous advance pulse |
| rst_pin | input | 1 | Asynchronous pointer-reset pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address: 0x00 control, 0x01 depth, 0x02 manual, 0x10+m mode words, 0x20+s state map |
| wr_data | input | CFG_W | Write data |
| cfg_out | output | CFG_W | Configuration bits driven downstream |
| cur_state | output | PTR_W | Current state pointer |
| cur_mode | output | MIDX_W | Mode index selected by the current state |

## Verification
The hardest situation to reach is a pulse that is still high under latching. The pointer and mode report have moved, but the outputs must still show the previous word. The bench holds the advance pin high for several cycles and samples all three outputs mid-pulse, then samples again after the fall. A second hard case is a manual value blocked behind an enabled latch while the sequencer is off. The bench reaches it by turning latching on from inside a run, disabling the sequencer, writing a new manual word, and only then pulsing the reset pin.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

    typedef enum logic [1:0] {
        CM_PASS  = 2'd0,
        CM_HOLD  = 2'd1,
        CM_ARMED = 2'd2
    } commit_state_t;

    localparam int PAGE_CTRL = 0;
    localparam int PAGE_MODE = 1;
    localparam int PAGE_MAP  = 2;

    localparam int IDX_CTRL   = 0;
    localparam int IDX_DEPTH  = 1;
    localparam int IDX_MANUAL = 2;

    localparam int CTRL_EN_BIT    = 0;
    localparam int CTRL_LATCH_BIT = 1;
    localparam int CTRL_SWADV_BIT = 2;
    localparam int CTRL_SWRST_BIT = 3;

endpackage

// File: rtl/mseq_edge.sv
module mseq_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    input  logic sw_pulse,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int N = (STAGES < 2) ? 2 : STAGES;

    logic [N-1:0] sync_q;
    logic         last_q;
    logic         sw_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
            sw_q   <= 1'b0;
        end else begin
            sync_q <= {sync_q[N-2:0], pin_async};
            last_q <= sync_q[N-1];
            sw_q   <= sw_pulse;
        end
    end

    // software pulse rises in its write cycle and falls one cycle later
    assign rise_evt = (sync_q[N-1] & ~last_q) | sw_pulse;
    assign fall_evt = (~sync_q[N-1] & last_q) | sw_q;

endmodule

// File: rtl/mseq_regs.sv
module mseq_regs
    import mseq_pkg::*;
#(
    parameter int CFG_W      = 8,
    parameter int NUM_MODES  = 8,
    parameter int MAX_STATES = 7,
    parameter int ADDR_W     = 6
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [ADDR_W-1:0]                     wr_addr,
    input  logic [CFG_W-1:0]                      wr_data,
    output logic                                  en_o,
    output logic                                  latch_o,
    output logic [$clog2(MAX_STATES+1)-1:0]       depth_o,
    output logic [CFG_W-1:0]                      manual_o,
    output logic [NUM_MODES-1:0][CFG_W-1:0]       mode_tab_o,
    output logic [MAX_STATES:0][((NUM_MODES > 1) ? $clog2(NUM_MODES) : 1)-1:0] state_map_o,
    output logic                                  sw_adv_o,
    output logic                                  sw_rst_o
);
    localparam int MIDX_W = (NUM_MODES > 1) ? $clog2(NUM_MODES) : 1;
    localparam int PTR_W  = $clog2(MAX_STATES + 1);
    localparam int PG_W   = ADDR_W - 4;
    localparam logic [PG_W-1:0]  PG_CTRL_L = PG_W'(PAGE_CTRL);
    localparam logic [PG_W-1:0]  PG_MODE_L = PG_W'(PAGE_MODE);
    localparam logic [PG_W-1:0]  PG_MAP_L  = PG_W'(PAGE_MAP);
    localparam logic [PTR_W-1:0] MAX_PTR   = PTR_W'(MAX_STATES);

    logic [PG_W-1:0] page;
    logic [3:0]      idx;
    logic            ctrl_hit, depth_hit, man_hit, mode_hit, map_hit;

    assign page      = wr_addr[ADDR_W-1:4];
    assign idx       = wr_addr[3:0];
    assign ctrl_hit  = wr_en && (page == PG_CTRL_L) && (idx == 4'(IDX_CTRL));
    assign depth_hit = wr_en && (page == PG_CTRL_L) && (idx == 4'(IDX_DEPTH));
    assign man_hit   = wr_en && (page == PG_CTRL_L) && (idx == 4'(IDX_MANUAL));
    assign mode_hit  = wr_en && (page == PG_MODE_L);
    assign map_hit   = wr_en && (page == PG_MAP_L);

    assign sw_adv_o = ctrl_hit && wr_data[CTRL_SWADV_BIT];
    assign sw_rst_o = ctrl_hit && wr_data[CTRL_SWRST_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_o     <= 1'b0;
            latch_o  <= 1'b0;
            depth_o  <= '0;
            manual_o <= '0;
        end else begin
            if (ctrl_hit) begin
                en_o    <= wr_data[CTRL_EN_BIT];
                latch_o <= wr_data[CTRL_LATCH_BIT];
            end
            if (depth_hit) begin
                if (int'(wr_data) > MAX_STATES) depth_o <= MAX_PTR;
                else                            depth_o <= wr_data[PTR_W-1:0];
            end
            if (man_hit) manual_o <= wr_data;
        end
    end

    logic [CFG_W-1:0]  mode_mem [NUM_MODES];
    logic [MIDX_W-1:0] map_mem  [MAX_STATES+1];

    for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           mode_mem[m] <= '0;
            else if (mode_hit && idx == 4'(m))    mode_mem[m] <= wr_data;
        end
        assign mode_tab_o[m] = mode_mem[m];
    end

    // home state entry is fixed to mode 0 and has no storage
    assign map_mem[0]     = '0;
    assign state_map_o[0] = '0;
    for (genvar s = 1; s <= MAX_STATES; s++) begin : g_map
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          map_mem[s] <= '0;
            else if (map_hit && idx == 4'(s))    map_mem[s] <= wr_data[MIDX_W-1:0];
        end
        assign state_map_o[s] = map_mem[s];
    end

endmodule

// File: rtl/mseq_pointer.sv
module mseq_pointer #(
    parameter int CFG_W      = 8,
    parameter int NUM_MODES  = 8,
    parameter int MAX_STATES = 7
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  en,
    input  logic [$clog2(MAX_STATES+1)-1:0]       depth,
    input  logic                                  adv_evt,
    input  logic                                  rst_evt,
    input  logic [NUM_MODES-1:0][CFG_W-1:0]       mode_tab,
    input  logic [MAX_STATES:0][((NUM_MODES > 1) ? $clog2(NUM_MODES) : 1)-1:0] state_map,
    output logic [$clog2(MAX_STATES+1)-1:0]       ptr_o,
    output logic [((NUM_MODES > 1) ? $clog2(NUM_MODES) : 1)-1:0] mode_o,
    output logic [CFG_W-1:0]                      hold_o
);
    localparam int MIDX_W = (NUM_MODES > 1) ? $clog2(NUM_MODES) : 1;
    localparam int PTR_W  = $clog2(MAX_STATES + 1);

    logic [PTR_W-1:0]  nxt_ptr;
    logic [MIDX_W-1:0] nxt_mode;

    always_comb begin
        if (rst_evt)                nxt_ptr = '0;
        else if (adv_evt)           nxt_ptr = (ptr_o >= depth) ? '0 : ptr_o + PTR_W'(1);
        else                        nxt_ptr = ptr_o;
        nxt_mode = state_map[nxt_ptr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_o  <= '0;
            mode_o <= '0;
            hold_o <= '0;
        end else if (!en) begin
            ptr_o  <= '0;
            mode_o <= '0;
            hold_o <= mode_tab[0];
        end else if (rst_evt || adv_evt) begin
            ptr_o  <= nxt_ptr;
            mode_o <= nxt_mode;
            hold_o <= mode_tab[nxt_mode];
        end
    end

    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && adv_evt && !rst_evt && ptr_o < depth) |=> (ptr_o == $past(ptr_o) + PTR_W'(1)));

    a_r4_wrap_home: assert property (@(posedge clk) disable iff (!rst_n)
        (en && adv_evt && !rst_evt && ptr_o >= depth) |=> (ptr_o == '0));

    a_r6_reset_home: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rst_evt) |=> (ptr_o == '0));

    a_r8_reset_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rst_evt && adv_evt) |=> (ptr_o == '0 && mode_o == '0));

endmodule

// File: rtl/mseq_commit.sv
module mseq_commit
    import mseq_pkg::*;
#(
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             latch_en,
    input  logic [CFG_W-1:0] source,
    input  logic             rise_evt,
    input  logic             fall_evt,
    output logic [CFG_W-1:0] cfg_o
);
    commit_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CM_PASS:  if (latch_en) state_d = CM_HOLD;
            CM_HOLD:  if (!latch_en) state_d = CM_PASS;
                      else if (rise_evt) state_d = CM_ARMED;
            CM_ARMED: if (!latch_en) state_d = CM_PASS;
                      else if (fall_evt) state_d = CM_HOLD;
            default:  state_d = CM_PASS;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CM_PASS;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_o <= '0;
        end else begin
            unique case (state_q)
                CM_PASS:  cfg_o <= source;
                CM_ARMED: if (fall_evt) cfg_o <= source;
                default:  cfg_o <= cfg_o;
            endcase
        end
    end

    // R9 / R10: frozen output outside a falling commit
    a_r9_frozen_until_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CM_PASS && !(state_q == CM_ARMED && fall_evt)) |=> $stable(cfg_o));

endmodule

// File: rtl/mode_sequencer.sv
module mode_sequencer #(
    parameter int CFG_W       = 8,
    parameter int NUM_MODES   = 8,
    parameter int MAX_STATES  = 7,
    parameter int ADDR_W      = 6,
    parameter int SYNC_STAGES = 2,
    localparam int MIDX_W = (NUM_MODES > 1) ? $clog2(NUM_MODES) : 1,
    localparam int PTR_W  = $clog2(MAX_STATES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_pin,
    input  logic              rst_pin,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CFG_W-1:0]  wr_data,
    output logic [CFG_W-1:0]  cfg_out,
    output logic [PTR_W-1:0]  cur_state,
    output logic [MIDX_W-1:0] cur_mode
);
    logic                              en, latch;
    logic [PTR_W-1:0]                  depth;
    logic [CFG_W-1:0]                  manual, hold, source;
    logic [NUM_MODES-1:0][CFG_W-1:0]   mode_tab;
    logic [MAX_STATES:0][MIDX_W-1:0]   state_map;
    logic                              sw_adv, sw_rst;
    logic                              adv_rise, adv_fall, rst_rise, rst_fall;

    mseq_regs #(
        .CFG_W(CFG_W), .NUM_MODES(NUM_MODES), .MAX_STATES(MAX_STATES), .ADDR_W(ADDR_W)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .en_o(en), .latch_o(latch), .depth_o(depth), .manual_o(manual),
        .mode_tab_o(mode_tab), .state_map_o(state_map),
        .sw_adv_o(sw_adv), .sw_rst_o(sw_rst)
    );

    mseq_edge #(.STAGES(SYNC_STAGES)) adv_edge_i (
        .clk(clk), .rst_n(rst_n), .pin_async(adv_pin), .sw_pulse(sw_adv),
        .rise_evt(adv_rise), .fall_evt(adv_fall)
    );

    mseq_edge #(.STAGES(SYNC_STAGES)) rst_edge_i (
        .clk(clk), .rst_n(rst_n), .pin_async(rst_pin), .sw_pulse(sw_rst),
        .rise_evt(rst_rise), .fall_evt(rst_fall)
    );

    mseq_pointer #(
        .CFG_W(CFG_W), .NUM_MODES(NUM_MODES), .MAX_STATES(MAX_STATES)
    ) ptr_i (
        .clk(clk), .rst_n(rst_n), .en(en), .depth(depth),
        .adv_evt(adv_rise), .rst_evt(rst_rise),
        .mode_tab(mode_tab), .state_map(state_map),
        .ptr_o(cur_state), .mode_o(cur_mode), .hold_o(hold)
    );

    assign source = en ? hold : manual;

    mseq_commit #(.CFG_W(CFG_W)) commit_i (
        .clk(clk), .rst_n(rst_n), .latch_en(latch), .source(source),
        .rise_evt(adv_rise | rst_rise), .fall_evt(adv_fall | rst_fall),
        .cfg_o(cfg_out)
    );

    a_r5_home_mode_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == '0) |-> (cur_mode == '0));

endmodule

// File: tb/mode_sequencer_tb_top.sv
module mode_sequencer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       adv_pin = 1'b0;
    logic       rst_pin = 1'b0;
    logic       wr_en = 1'b0;
    logic [5:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] cfg_out;
    logic [2:0] cur_state;
    logic [2:0] cur_mode;

    always #2.5ns clk = ~clk;

    mode_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .adv_pin(adv_pin), .rst_pin(rst_pin),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cfg_out(cfg_out), .cur_state(cur_state), .cur_mode(cur_mode)
    );

    typedef struct {
        string      tag;
        logic [7:0] cfg;
        logic [2:0] st;
        logic [2:0] md;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 0;

    logic [7:0] mt [8];
    logic [2:0] mp [8];

    // monitor: compares every queued expectation at the next falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_chk++;
                if (cfg_out !== e.cfg || cur_state !== e.st || cur_mode !== e.md) begin
                    n_bad++;
                    $display("FAIL %s: got cfg=%h st=%0d md=%0d, expected cfg=%h st=%0d md=%0d",
                             e.tag, cfg_out, cur_state, cur_mode, e.cfg, e.st, e.md);
                end
            end
        end
    end

    task automatic expect_out(string tag, logic [7:0] c, logic [2:0] s, logic [2:0] m);
        exp_t e;
        e.tag = tag; e.cfg = c; e.st = s; e.md = m;
        sb_q.push_back(e);
        @(negedge clk);
        #1ns;
    endtask

    function automatic logic [7:0] cfg_of(int s);
        return (s == 0) ? mt[0] : mt[mp[s]];
    endfunction

    function automatic logic [2:0] md_of(int s);
        return (s == 0) ? 3'd0 : mp[s];
    endfunction

    task automatic expect_state(string tag, int s);
        expect_out(tag, cfg_of(s), 3'(s), md_of(s));
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic reg_wr(logic [5:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        settle();
    endtask

    task automatic pulse_adv(int hi);
        @(negedge clk);
        adv_pin = 1'b1;
        repeat (hi) @(negedge clk);
        adv_pin = 1'b0;
        settle();
    endtask

    task automatic pulse_rst(int hi);
        @(negedge clk);
        rst_pin = 1'b1;
        repeat (hi) @(negedge clk);
        rst_pin = 1'b0;
        settle();
    endtask

    // watchdog
    initial begin
        #(5ns * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int m = 0; m < 8; m++) mt[m] = 8'((m * 37 + 5) & 255);
        mp[0] = 3'd0;
        for (int s = 1; s < 8; s++) mp[s] = 3'((s * 3) % 5);

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R1 reset state", 8'h00, 3'd0, 3'd0);

        // R2: disabled, latching off, manual drives output, pins ignored
        reg_wr(6'h02, 8'h3C);
        expect_out("R2 manual passes through", 8'h3C, 3'd0, 3'd0);
        pulse_adv(3);
        expect_out("R2 advance ignored while disabled", 8'h3C, 3'd0, 3'd0);

        for (int m = 0; m < 8; m++) reg_wr(6'h10 + 6'(m), mt[m]);
        for (int s = 1; s < 8; s++) reg_wr(6'h20 + 6'(s), 8'(mp[s]));
        reg_wr(6'h20, 8'h05);                 // R5: home entry not writable
        reg_wr(6'h01, 8'd3);
        reg_wr(6'h00, 8'h01);                 // enable
        expect_state("R5 home state selects mode 0", 0);

        // R3: pin advances through states 1..3
        for (int s = 1; s <= 3; s++) begin
            pulse_adv(3);
            expect_state("R3 pin advance", s);
        end
        pulse_adv(3);
        expect_state("R4 wrap after depth", 0);

        // R7: software advance
        reg_wr(6'h00, 8'h05);
        expect_state("R7 software advance", 1);
        reg_wr(6'h00, 8'h05);
        expect_state("R7 second software advance", 2);

        // R6: pin and software reset
        pulse_rst(3);
        expect_state("R6 pin reset", 0);
        reg_wr(6'h00, 8'h05);
        reg_wr(6'h00, 8'h09);
        expect_state("R6 software reset", 0);

        // R8: simultaneous reset and advance
        reg_wr(6'h00, 8'h05);
        expect_state("R8 setup state 1", 1);
        reg_wr(6'h00, 8'h0D);
        expect_state("R8 reset beats advance", 0);

        // R4: depth zero keeps pointer home
        reg_wr(6'h01, 8'd0);
        pulse_adv(3);
        expect_state("R4 depth zero stays home", 0);

        // R11: oversize depth clamps to 7
        reg_wr(6'h01, 8'd20);
        for (int s = 1; s <= 7; s++) begin
            reg_wr(6'h00, 8'h05);
            expect_state("R11 clamped depth walk", s);
        end
        reg_wr(6'h00, 8'h05);
        expect_state("R11 wrap after clamped depth", 0);

        // R9: latched output update
        reg_wr(6'h00, 8'h03);
        expect_state("R9 latch on, home", 0);
        @(negedge clk);
        adv_pin = 1'b1;
        repeat (8) @(negedge clk);
        expect_out("R9 mid-pulse output frozen", mt[0], 3'd1, mp[1]);
        adv_pin = 1'b0;
        settle();
        expect_state("R9 output after fall", 1);

        // R10: latched and disabled, manual blocked until pulse
        reg_wr(6'h00, 8'h02);
        reg_wr(6'h02, 8'h77);
        expect_out("R10 manual blocked by latch", cfg_of(1), 3'd0, 3'd0);
        pulse_rst(4);
        expect_out("R10 manual after pin pulse", 8'h77, 3'd0, 3'd0);

        // R2: latch off again, manual follows directly
        reg_wr(6'h00, 8'h00);
        reg_wr(6'h02, 8'h81);
        expect_out("R2 manual follows after latch off", 8'h81, 3'd0, 3'd0);

        repeat (2) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule